// File: doc/BRIEF.md
# Interrupt Routing and Status Decode

This block collects interrupt events from several groups of sources and holds each event as a pending status bit. Software clears a pending bit by writing a one to the clear register of its group. Each source also has a four-bit routing field that chooses one of eight physical interrupt lines. Field values 8 to 15 send the source nowhere.

For every destination line the block builds a decode register. Each bit of that register is the OR of the pending sources that are routed to that line and that the fixed mapping assigns to that bit. A handler can therefore find the group, and for the doorbell groups the source index modulo four, with a single read. It does not have to scan every status group. An interrupt line is high while its decode register is non-zero.

Access is through a 32-bit register port. Reads are combinational and writes take effect at a clock edge. The default build has eight groups of twelve sources, and the first four groups are doorbell groups.

Top module: `irq_route_top`

## Requirements
- R1: After reset, every status bit, routing field, decode register and `irq_out` line is zero.
- R2: A one-cycle pulse on `src_evt[g*S+s]` sets bit s of the status register of group g at the next rising edge. The status register of group g is read at 0x200+0x10*g, and S is the number of sources per group. The bit stays set until it is cleared.
- R3: A write to the clear register of group g, at 0x204+0x10*g, clears the status bits whose data bit is 1. It leaves all other bits unchanged. The clear register reads as zero.
- R4: When a set pulse and a clear of the same bit happen in the same cycle, the bit ends up set.
- R5: After reset, and with no routing write, every pending source is reported on destination 0.
- R6: The routing register at 0x300+4*(g*P+k) holds the fields for sources 8k to 8k+7 of group g, where P = ceil(S/8). Field j occupies bits 4j+3:4j. Fields for source indices at or above S read as zero and ignore writes. A routing register holds its value while no write is made to it.
- R7: The decode register of destination d, at 0x280+4*d, reflects only the pending sources whose routing field equals d.
- R8: In the decode register, a source s of doorbell group g (g<4) maps to bit 4g+(s mod 4). Group g≥4 maps to bit 16+(g-4). Bits 31:20 read as zero.
- R9: A decode bit stays set while any pending, routed source that maps to it remains. It clears only when the last such source clears.
- R10: `irq_out[d]` is high exactly when decode register d is non-zero. It follows a status change with no added register stage.
- R11: A source whose routing field is 8 to 15 sets no decode bit and no `irq_out` line, even while it is pending.
- R12: A read of any other address, including any address whose two low bits are non-zero, returns zero. Writes to status, decode or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_GROUPS*SRC_PER_GROUP | One-cycle set pulses, group-major |
| bus_addr | input | 12 | Byte address of register access |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 8 | Level interrupt per destination |

## Verification
A table of vectors places one pending source in every group, with each source routed to a different line. Each vector reads all eight decode registers and the line vector. This tells apart a wrong destination, a wrong bit position, and a doorbell index folded by the wrong modulus. Two vectors use routing codes 9 and 15, to separate "routed nowhere" from "routed to line 1 or 7". Directed cases then pile two sources onto one decode bit, split them across two lines, and clear them one at a time. This separates an OR from a last-writer mux. Further cases cover set-versus-clear collisions, writes of all ones to a partly used routing register, and accesses that fall between or below the mapped windows.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
   localparam int NUM_DEST       = 8;
   localparam int FIELD_W        = 4;
   localparam int ADDR_W         = 12;
   localparam int DATA_W         = 32;
   localparam int FIELDS_PER_REG = DATA_W / FIELD_W;
   localparam int GROUP_STRIDE   = 16;
   localparam int DB_BITS        = 4;

   localparam logic [ADDR_W-1:0] STAT_BASE  = 12'h200;
   localparam logic [ADDR_W-1:0] DEC_BASE   = 12'h280;
   localparam logic [ADDR_W-1:0] ROUTE_BASE = 12'h300;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_STAT,
      REG_CLR,
      REG_DEC,
      REG_ROUTE
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [6:0] idx;
   } reg_sel_t;
endpackage

// File: rtl/irq_addr_decode.sv
`timescale 1ns/1ps
module irq_addr_decode
   import irq_route_pkg::*;
#(
   parameter int NUM_GROUPS     = 8,
   parameter int NUM_ROUTE_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);
   localparam logic [ADDR_W-1:0] STAT_SPAN  = ADDR_W'(NUM_GROUPS * GROUP_STRIDE);
   localparam logic [ADDR_W-1:0] DEC_SPAN   = ADDR_W'(NUM_DEST * 4);
   localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(NUM_ROUTE_REGS * 4);

   logic [ADDR_W-1:0] stat_ofs, dec_ofs, route_ofs;
   logic              aligned;

   assign stat_ofs  = addr - STAT_BASE;
   assign dec_ofs   = addr - DEC_BASE;
   assign route_ofs = addr - ROUTE_BASE;
   assign aligned   = (addr[1:0] == 2'b00);

   always_comb begin
      sel.kind = REG_NONE;
      sel.idx  = '0;
      if (aligned) begin
         if (addr >= STAT_BASE && stat_ofs < STAT_SPAN) begin
            sel.idx = {4'b0, stat_ofs[6:4]};
            case (stat_ofs[3:2])
               2'd0:    sel.kind = REG_STAT;
               2'd1:    sel.kind = REG_CLR;
               default: sel.kind = REG_NONE;
            endcase
         end else if (addr >= DEC_BASE && dec_ofs < DEC_SPAN) begin
            sel.kind = REG_DEC;
            sel.idx  = {4'b0, dec_ofs[4:2]};
         end else if (addr >= ROUTE_BASE && route_ofs < ROUTE_SPAN) begin
            sel.kind = REG_ROUTE;
            sel.idx  = route_ofs[8:2];
         end
      end
   end

   // R12: addresses below the status window or misaligned never select a register
   assert_unmapped_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (addr < STAT_BASE || addr[1:0] != 2'b00) |-> (sel.kind == REG_NONE));
endmodule

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_pulse,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] stat
);
   logic [WIDTH-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr_eff) | set_pulse;
   end

   // R4: a pulse always lands, even against a clear
   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pulse != '0) |=> ((stat & $past(set_pulse)) == $past(set_pulse)));

   // R3: cleared bits without a competing pulse are zero next cycle
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((stat & $past(clr_mask & ~set_pulse)) == '0));

   // R2: without a clear, no pending bit is lost
   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/irq_route_table.sv
`timescale 1ns/1ps
module irq_route_table
   import irq_route_pkg::*;
#(
   parameter int NUM_GROUPS    = 8,
   parameter int SRC_PER_GROUP = 12
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    wr_en,
   input  logic [6:0]                              idx,
   input  logic [DATA_W-1:0]                       wdata,
   output logic [DATA_W-1:0]                       rd_data,
   output logic [NUM_GROUPS*SRC_PER_GROUP*FIELD_W-1:0] route_flat
);
   localparam int NSRC = NUM_GROUPS * SRC_PER_GROUP;
   localparam int RPG  = (SRC_PER_GROUP + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

   logic [FIELD_W-1:0] fld [NSRC];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NSRC; i++) fld[i] <= '0;
      end else if (wr_en) begin
         for (int g = 0; g < NUM_GROUPS; g++) begin
            for (int k = 0; k < RPG; k++) begin
               for (int j = 0; j < FIELDS_PER_REG; j++) begin
                  if (idx == 7'(g*RPG + k) && (k*FIELDS_PER_REG + j) < SRC_PER_GROUP)
                     fld[g*SRC_PER_GROUP + k*FIELDS_PER_REG + j] <= wdata[j*FIELD_W +: FIELD_W];
               end
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         for (int k = 0; k < RPG; k++) begin
            for (int j = 0; j < FIELDS_PER_REG; j++) begin
               if (idx == 7'(g*RPG + k) && (k*FIELDS_PER_REG + j) < SRC_PER_GROUP)
                  rd_data[j*FIELD_W +: FIELD_W] = fld[g*SRC_PER_GROUP + k*FIELDS_PER_REG + j];
            end
         end
      end
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_flat
         assign route_flat[i*FIELD_W +: FIELD_W] = fld[i];
      end
   endgenerate

   // R6: routing fields hold without a write strobe
   assert_route_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(route_flat));
endmodule

// File: rtl/irq_dest_decode.sv
`timescale 1ns/1ps
module irq_dest_decode
   import irq_route_pkg::*;
#(
   parameter int NUM_GROUPS      = 8,
   parameter int SRC_PER_GROUP   = 12,
   parameter int DOORBELL_GROUPS = 4,
   parameter int DEC_W           = 20
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0]         stat_flat,
   input  logic [NUM_GROUPS*SRC_PER_GROUP*FIELD_W-1:0] route_flat,
   output logic [NUM_DEST-1:0][DEC_W-1:0]              dec
);
   localparam int NSRC = NUM_GROUPS * SRC_PER_GROUP;

   function automatic int dec_bit(input int g, input int s);
      if (g < DOORBELL_GROUPS) return DB_BITS*g + (s % DB_BITS);
      else                     return DB_BITS*DOORBELL_GROUPS + (g - DOORBELL_GROUPS);
   endfunction

   always_comb begin
      dec = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         for (int s = 0; s < SRC_PER_GROUP; s++) begin
            for (int d = 0; d < NUM_DEST; d++) begin
               if (stat_flat[g*SRC_PER_GROUP + s] &&
                   route_flat[(g*SRC_PER_GROUP + s)*FIELD_W +: FIELD_W] == FIELD_W'(d))
                  dec[d][dec_bit(g, s)] = 1'b1;
            end
         end
      end
   end

   logic [NSRC-1:0] live;
   always_comb begin
      for (int i = 0; i < NSRC; i++)
         live[i] = stat_flat[i] && !route_flat[i*FIELD_W + FIELD_W - 1];
   end

   // R11: sources parked on codes 8..15 never reach a decode register
   assert_parked_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (live == '0) |-> (dec == '0));
endmodule

// File: rtl/irq_route_top.sv
`timescale 1ns/1ps
module irq_route_top
   import irq_route_pkg::*;
#(
   parameter int NUM_GROUPS      = 8,
   parameter int SRC_PER_GROUP   = 12,
   parameter int DOORBELL_GROUPS = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] src_evt,
   input  logic [11:0]                         bus_addr,
   input  logic                                bus_wr,
   input  logic [31:0]                         bus_wdata,
   output logic [31:0]                         bus_rdata,
   output logic [7:0]                          irq_out
);
   localparam int NSRC   = NUM_GROUPS * SRC_PER_GROUP;
   localparam int RPG    = (SRC_PER_GROUP + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
   localparam int NROUTE = NUM_GROUPS * RPG;
   localparam int DEC_W  = DB_BITS*DOORBELL_GROUPS + (NUM_GROUPS - DOORBELL_GROUPS);

   generate
      if (SRC_PER_GROUP < 4 || SRC_PER_GROUP > 32 || (SRC_PER_GROUP % 4) != 0) begin : g_bad_src
         $error("SRC_PER_GROUP must be a multiple of 4 in 4..32");
      end
      if (NUM_GROUPS < 1 || NUM_GROUPS > 8) begin : g_bad_grp
         $error("NUM_GROUPS must be 1..8");
      end
      if (DOORBELL_GROUPS > NUM_GROUPS) begin : g_bad_db
         $error("DOORBELL_GROUPS exceeds NUM_GROUPS");
      end
      if (NROUTE > 64 || DEC_W > DATA_W) begin : g_bad_map
         $error("routing or decode map does not fit its window");
      end
   endgenerate

   reg_sel_t                         sel;
   logic [NSRC-1:0]                  stat_flat;
   logic [NSRC*FIELD_W-1:0]          route_flat;
   logic [DATA_W-1:0]                route_rd;
   logic [NUM_DEST-1:0][DEC_W-1:0]   dec;

   irq_addr_decode #(
      .NUM_GROUPS     (NUM_GROUPS),
      .NUM_ROUTE_REGS (NROUTE)
   ) u_adec (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .sel   (sel)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
         logic clr_hit;
         assign clr_hit = bus_wr && sel.kind == REG_CLR && sel.idx == 7'(g);
         irq_status_bank #(.WIDTH(SRC_PER_GROUP)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_pulse (src_evt[g*SRC_PER_GROUP +: SRC_PER_GROUP]),
            .clr_we    (clr_hit),
            .clr_mask  (bus_wdata[SRC_PER_GROUP-1:0]),
            .stat      (stat_flat[g*SRC_PER_GROUP +: SRC_PER_GROUP])
         );
      end
   endgenerate

   irq_route_table #(
      .NUM_GROUPS    (NUM_GROUPS),
      .SRC_PER_GROUP (SRC_PER_GROUP)
   ) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr && sel.kind == REG_ROUTE),
      .idx        (sel.idx),
      .wdata      (bus_wdata),
      .rd_data    (route_rd),
      .route_flat (route_flat)
   );

   irq_dest_decode #(
      .NUM_GROUPS      (NUM_GROUPS),
      .SRC_PER_GROUP   (SRC_PER_GROUP),
      .DOORBELL_GROUPS (DOORBELL_GROUPS),
      .DEC_W           (DEC_W)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .stat_flat  (stat_flat),
      .route_flat (route_flat),
      .dec        (dec)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel.kind)
         REG_STAT: begin
            for (int g = 0; g < NUM_GROUPS; g++)
               if (sel.idx == 7'(g))
                  bus_rdata = DATA_W'(stat_flat[g*SRC_PER_GROUP +: SRC_PER_GROUP]);
         end
         REG_DEC:   bus_rdata = DATA_W'(dec[sel.idx[2:0]]);
         REG_ROUTE: bus_rdata = route_rd;
         default:   bus_rdata = '0;
      endcase
   end

   generate
      for (genvar d = 0; d < NUM_DEST; d++) begin : g_line
         assign irq_out[d] = |dec[d];
      end
   endgenerate

   // R10: with nothing pending, every line is low
   assert_quiet_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_flat == '0) |-> (irq_out == '0));
endmodule

// File: tb/sim_irq_route_top.sv
`timescale 1ns/1ps
module sim_irq_route_top;
   localparam int NG = 8;
   localparam int NS = 12;

   typedef struct packed {
      logic [2:0] grp;
      logic [4:0] src;
      logic [3:0] rte;
      logic [4:0] ebit;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{3'd0, 5'd0,  4'd0,  5'd0},
      '{3'd1, 5'd5,  4'd3,  5'd5},
      '{3'd2, 5'd10, 4'd7,  5'd10},
      '{3'd3, 5'd7,  4'd2,  5'd15},
      '{3'd4, 5'd11, 4'd5,  5'd16},
      '{3'd5, 5'd0,  4'd1,  5'd17},
      '{3'd6, 5'd9,  4'd6,  5'd18},
      '{3'd7, 5'd3,  4'd4,  5'd19},
      '{3'd7, 5'd4,  4'd9,  5'd0},
      '{3'd0, 5'd8,  4'd15, 5'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NG*NS-1:0]  src_evt = '0;
   logic [11:0]       bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [7:0]        irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_route_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_evt   (src_evt),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   function automatic logic [11:0] a_stat(input int g);  return 12'(32'h200 + 16*g);     endfunction
   function automatic logic [11:0] a_clr(input int g);   return 12'(32'h204 + 16*g);     endfunction
   function automatic logic [11:0] a_dec(input int d);   return 12'(32'h280 + 4*d);      endfunction
   function automatic logic [11:0] a_route(input int r); return 12'(32'h300 + 4*r);      endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic lines(output logic [7:0] v);
      @(negedge clk);
      #1 v = irq_out;
   endtask

   task automatic pulse(input int i);
      @(negedge clk);
      src_evt[i] = 1'b1;
      @(negedge clk);
      src_evt[i] = 1'b0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  l;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      lines(l); check("R1 lines", 32'(l), 32'h0);
      for (int g = 0; g < NG; g++) begin
         rd(a_stat(g), v); check("R1 status", v, 32'h0);
      end
      for (int r = 0; r < 16; r++) begin
         rd(a_route(r), v); check("R1 route", v, 32'h0);
      end
      for (int d = 0; d < 8; d++) begin
         rd(a_dec(d), v); check("R1 decode", v, 32'h0);
      end

      // R5: default routing lands on destination 0
      pulse(4*NS + 2);
      lines(l); check("R5 line", 32'(l), 32'h01);
      rd(a_dec(0), v); check("R5 decode0", v, 32'h0001_0000);
      wr(a_clr(4), 32'h4);
      lines(l); check("R5 cleared", 32'(l), 32'h0);

      // Vector table: R7, R8, R11, R2, R3, R10
      for (int n = 0; n < 10; n++) begin
         int g, s, r, f;
         logic [31:0] exp;
         g = int'(VEC[n].grp); s = int'(VEC[n].src);
         r = g*2 + s/8; f = s % 8;
         wr(a_route(r), 32'(VEC[n].rte) << (4*f));
         pulse(g*NS + s);
         rd(a_stat(g), v); check("R2 status set", v, 32'(1) << s);
         for (int d = 0; d < 8; d++) begin
            exp = (VEC[n].rte < 8 && d == int'(VEC[n].rte)) ? (32'(1) << VEC[n].ebit) : 32'h0;
            rd(a_dec(d), v);
            check(VEC[n].rte < 8 ? "R7 R8 decode" : "R11 parked decode", v, exp);
         end
         lines(l);
         check(VEC[n].rte < 8 ? "R10 line" : "R11 parked line", 32'(l),
               VEC[n].rte < 8 ? (32'(1) << VEC[n].rte) : 32'h0);
         wr(a_clr(g), 32'(1) << s);
         rd(a_stat(g), v); check("R3 status cleared", v, 32'h0);
         lines(l); check("R10 line low", 32'(l), 32'h0);
         wr(a_route(r), 32'h0);
      end

      // R2 hold, R12 write to status ignored, R3 partial clear
      pulse(1);
      repeat (5) @(negedge clk);
      rd(a_stat(0), v); check("R2 hold", v, 32'h2);
      wr(a_stat(0), 32'hFFF);
      rd(a_stat(0), v); check("R12 status write ignored", v, 32'h2);
      wr(a_dec(0), 32'hFFFF_FFFF);
      rd(a_dec(0), v); check("R12 decode write ignored", v, 32'h2);
      wr(a_clr(0), 32'h0);
      rd(a_stat(0), v); check("R3 zero mask keeps", v, 32'h2);
      rd(a_clr(0), v); check("R3 clear reads zero", v, 32'h0);
      wr(a_clr(0), 32'hFFD);
      rd(a_stat(0), v); check("R3 other bits untouched", v, 32'h2);
      wr(a_clr(0), 32'h2);
      rd(a_stat(0), v); check("R3 cleared", v, 32'h0);

      // R4: set and clear collide
      @(negedge clk);
      src_evt[2] = 1'b1; bus_addr = a_clr(0); bus_wdata = 32'h4; bus_wr = 1'b1;
      @(negedge clk);
      src_evt[2] = 1'b0; bus_wr = 1'b0;
      rd(a_stat(0), v); check("R4 set wins", v, 32'h4);
      wr(a_clr(0), 32'h4);

      // R6: packing and unused upper fields
      wr(a_route(1), 32'hFFFF_FFFF);
      rd(a_route(1), v); check("R6 upper fields zero", v, 32'h0000_FFFF);
      wr(a_route(0), 32'h7654_3210);
      rd(a_route(0), v); check("R6 readback", v, 32'h7654_3210);
      rd(a_route(2), v); check("R6 neighbour untouched", v, 32'h0);
      pulse(6);
      lines(l); check("R6 field 6 routes to 6", 32'(l), 32'h40);
      rd(a_dec(6), v); check("R6 R8 decode6", v, 32'h4);
      wr(a_clr(0), 32'h40);
      pulse(9);
      lines(l); check("R11 code 15 field", 32'(l), 32'h0);
      wr(a_clr(0), 32'h200);
      wr(a_route(0), 32'h0); wr(a_route(1), 32'h0);

      // R9 and R7: two sources on one decode bit, then split
      pulse(NS + 1);
      pulse(NS + 5);
      rd(a_dec(0), v); check("R9 shared bit", v, 32'h20);
      wr(a_clr(1), 32'h2);
      rd(a_dec(0), v); check("R9 bit held by other", v, 32'h20);
      wr(a_clr(1), 32'h20);
      rd(a_dec(0), v); check("R9 bit cleared", v, 32'h0);
      wr(a_route(2), 32'h0020_0000);
      pulse(NS + 1);
      pulse(NS + 5);
      rd(a_dec(0), v); check("R7 dest0 only own", v, 32'h20);
      rd(a_dec(2), v); check("R7 dest2 only own", v, 32'h20);
      lines(l); check("R10 two lines", 32'(l), 32'h05);
      wr(a_clr(1), 32'h2);
      lines(l); check("R10 one line left", 32'(l), 32'h04);
      wr(a_clr(1), 32'h20);
      wr(a_route(2), 32'h0);

      // R12: unmapped and misaligned reads
      pulse(0);
      rd(12'h000, v); check("R12 low addr", v, 32'h0);
      rd(12'h201, v); check("R12 misaligned", v, 32'h0);
      rd(12'h208, v); check("R12 group gap", v, 32'h0);
      rd(12'h2A0, v); check("R12 after decode", v, 32'h0);
      rd(12'h340, v); check("R12 after route", v, 32'h0);
      wr(12'h340, 32'hFFFF_FFFF);
      rd(a_stat(0), v); check("R12 stray write", v, 32'h1);
      lines(l); check("R12 lines unchanged", 32'(l), 32'h01);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule